// File: doc/BRIEF.md
# Lithium Charge Cycle Sequencer

This block steps a lithium battery through one charge cycle. It works from digital flags and measurement codes supplied by the rest of the charger: a battery-present flag, a battery-short flag, a flag that says the thermistor reading is inside the allowed temperature window, two flags for the input limit loops, and codes for battery current, battery voltage, the charge-voltage target and the C/x current threshold. A one-second tick drives two elapsed-time counters. One counter tracks total charging time. The other tracks time spent in constant-voltage regulation. Each counter is compared against its own limit, which is an input.

The block drives two registered one-hot words. The first names the sequencer state: idle, charging, thermistor pause, constant-voltage timeout, C/x termination, total-time fault, battery missing or battery shorted. The second names the control loop that sets the charge current while charging is under way. A charge cycle starts when the enable input goes high. It ends in one of the terminal states, and the block stays there until the enable input is dropped.

Top module: `li_charge_seq`

## Requirements
- R1: After reset, `state_o` is 8'h01 (idle) and `loop_o` is 4'h0. The state bits are: bit0 idle, bit1 charging, bit2 thermistor pause, bit3 constant-voltage timeout, bit4 C/x termination, bit5 total-time fault, bit6 battery missing, bit7 battery shorted.
- R2: A high `bat_short_i` moves the block to battery-shorted (8'h80) on the next edge, whatever else is true. Otherwise a low `bat_present_i` moves it to battery-missing (8'h40). When the fault condition clears, the block goes from either fault state to idle.
- R3: From idle, a high `chg_en_i` starts charging (8'h02) on the next edge. In every state other than the two battery faults, a low `chg_en_i` returns the block to idle.
- R4: While charging, a low `temp_ok_i` moves the block to thermistor pause (8'h04). A high `temp_ok_i` in pause returns it to charging.
- R5: The total-time counter adds one for each tick that arrives while the state is charging. It holds its value during thermistor pause and clears while idle. When the count, compared unsigned, is greater than `max_total_time_i`, the block goes from charging to total-time fault (8'h20).
- R6: The constant-voltage counter adds one for each tick that arrives while the state is charging and the registered loop is constant voltage. It clears while idle. When the count is greater than `max_cv_time_i`, the block goes from charging to constant-voltage timeout (8'h08).
- R7: While charging with the registered loop at constant voltage, `ibat_i` below `cx_thresh_i` (unsigned) ends the cycle in C/x termination (8'h10). The same current level in constant-current regulation has no effect.
- R8: While charging, the exits are taken in this priority order: thermistor pause first, then total-time fault, then constant-voltage timeout, then C/x termination.
- R9: The three terminal states (8'h08, 8'h10, 8'h20) hold while `chg_en_i` stays high and the battery is present and not shorted. Ticks, temperature and measurements have no effect on them.
- R10: `loop_o` is 4'h0 outside the charging state. In the charging state it holds exactly one bit, chosen in this priority order: bit3 input undervoltage limit (`uv_lim_i`), bit2 input current limit (`iin_lim_i`), bit0 constant voltage (`vbat_i` >= `vtarget_i`), bit1 constant current.
- R11: Both outputs come straight from flops. `state_o` always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second timebase pulse, one cycle wide |
| chg_en_i | input | 1 | Starts a charge cycle; low returns the block to idle |
| bat_present_i | input | 1 | A battery is detected |
| bat_short_i | input | 1 | A shorted battery is detected |
| temp_ok_i | input | 1 | Thermistor reading is inside the temperature window |
| uv_lim_i | input | 1 | Input undervoltage limit loop wants control |
| iin_lim_i | input | 1 | Input current limit loop wants control |
| ibat_i | input | ADC_W | Measured battery current code |
| vbat_i | input | ADC_W | Measured battery voltage code |
| vtarget_i | input | ADC_W | Charge-voltage target code |
| cx_thresh_i | input | ADC_W | C/x termination current threshold |
| max_cv_time_i | input | TIME_W | Constant-voltage time limit, in ticks |
| max_total_time_i | input | TIME_W | Total charge time limit, in ticks |
| state_o | output | 8 | One-hot sequencer state |
| loop_o | output | 4 | One-hot active control loop |

## Verification
A wrong state register shows at `state_o` on the edge after the stimulus, because the state word is the register itself. A wrong loop choice shows at `loop_o` on the same edge. Counter faults stay hidden until a limit is crossed. A counter that fails to hold during pause, runs outside constant-voltage regulation, or is not cleared on restart moves the fault or timeout edge by at least one tick. The bench therefore counts ticks up to each limit and checks the exact step on which the exit happens.

// File: rtl/li_chg_pkg.sv
package li_chg_pkg;

    localparam int N_STATES = 8;
    localparam int N_LOOPS  = 4;

    typedef enum logic [N_STATES-1:0] {
        ST_IDLE     = 8'h01,
        ST_CHARGING = 8'h02,
        ST_PAUSE    = 8'h04,
        ST_CV_TMO   = 8'h08,
        ST_CX_DONE  = 8'h10,
        ST_TIME_FLT = 8'h20,
        ST_NO_BATT  = 8'h40,
        ST_SHORTED  = 8'h80
    } chg_state_t;

    typedef enum logic [N_LOOPS-1:0] {
        LP_NONE = 4'h0,
        LP_CV   = 4'h1,
        LP_CC   = 4'h2,
        LP_IIN  = 4'h4,
        LP_UV   = 4'h8
    } loop_t;

    typedef struct packed {
        chg_state_t state;
        loop_t      loop;
    } seq_regs_t;

endpackage

// File: rtl/li_chg_tick_timer.sv
module li_chg_tick_timer #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              cnt_en_i,
    input  logic [TIME_W-1:0] limit_i,
    output logic [TIME_W-1:0] count_o,
    output logic              over_o
);

    localparam logic [TIME_W-1:0] CNT_MAX = '1;

    logic [TIME_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (cnt_en_i && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
    assign over_o  = (cnt_q > limit_i);

    AST_TMR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) && !clr_i |=> (cnt_q == CNT_MAX)); // R5
    AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/li_chg_loop_pick.sv
module li_chg_loop_pick
    import li_chg_pkg::*;
#(
    parameter int ADC_W = 16
) (
    input  logic             uv_lim_i,
    input  logic             iin_lim_i,
    input  logic [ADC_W-1:0] vbat_i,
    input  logic [ADC_W-1:0] vtarget_i,
    output loop_t            loop_o
);

    always_comb begin
        if (uv_lim_i) begin
            loop_o = LP_UV;
        end else if (iin_lim_i) begin
            loop_o = LP_IIN;
        end else if (vbat_i >= vtarget_i) begin
            loop_o = LP_CV;
        end else begin
            loop_o = LP_CC;
        end
    end

endmodule

// File: rtl/li_charge_seq.sv
module li_charge_seq
    import li_chg_pkg::*;
#(
    parameter int ADC_W  = 16,
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              chg_en_i,
    input  logic              bat_present_i,
    input  logic              bat_short_i,
    input  logic              temp_ok_i,
    input  logic              uv_lim_i,
    input  logic              iin_lim_i,
    input  logic [ADC_W-1:0]  ibat_i,
    input  logic [ADC_W-1:0]  vbat_i,
    input  logic [ADC_W-1:0]  vtarget_i,
    input  logic [ADC_W-1:0]  cx_thresh_i,
    input  logic [TIME_W-1:0] max_cv_time_i,
    input  logic [TIME_W-1:0] max_total_time_i,
    output logic [7:0]        state_o,
    output logic [3:0]        loop_o
);

    seq_regs_t         nxt_d, cur_q;
    loop_t             loop_pick;
    logic              in_chg, idle_clr, tot_en, cv_en;
    logic              tot_over, cv_over;
    logic [TIME_W-1:0] tot_cnt, cv_cnt;

    assign in_chg   = (cur_q.state == ST_CHARGING);
    assign idle_clr = (cur_q.state == ST_IDLE);
    assign tot_en   = in_chg && tick_i;
    assign cv_en    = tot_en && (cur_q.loop == LP_CV);

    li_chg_tick_timer #(.TIME_W(TIME_W)) i_total_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (idle_clr),
        .cnt_en_i (tot_en),
        .limit_i  (max_total_time_i),
        .count_o  (tot_cnt),
        .over_o   (tot_over)
    );

    li_chg_tick_timer #(.TIME_W(TIME_W)) i_cv_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (idle_clr),
        .cnt_en_i (cv_en),
        .limit_i  (max_cv_time_i),
        .count_o  (cv_cnt),
        .over_o   (cv_over)
    );

    li_chg_loop_pick #(.ADC_W(ADC_W)) i_loop_pick (
        .uv_lim_i  (uv_lim_i),
        .iin_lim_i (iin_lim_i),
        .vbat_i    (vbat_i),
        .vtarget_i (vtarget_i),
        .loop_o    (loop_pick)
    );

    always_comb begin
        nxt_d = cur_q;
        if (bat_short_i) begin
            nxt_d.state = ST_SHORTED;
        end else if (!bat_present_i) begin
            nxt_d.state = ST_NO_BATT;
        end else if ((cur_q.state == ST_SHORTED) || (cur_q.state == ST_NO_BATT)) begin
            nxt_d.state = ST_IDLE;
        end else if (!chg_en_i) begin
            nxt_d.state = ST_IDLE;
        end else begin
            case (cur_q.state)
                ST_IDLE: nxt_d.state = ST_CHARGING;
                ST_CHARGING: begin
                    if (!temp_ok_i) begin
                        nxt_d.state = ST_PAUSE;
                    end else if (tot_over) begin
                        nxt_d.state = ST_TIME_FLT;
                    end else if (cv_over) begin
                        nxt_d.state = ST_CV_TMO;
                    end else if ((cur_q.loop == LP_CV) && (ibat_i < cx_thresh_i)) begin
                        nxt_d.state = ST_CX_DONE;
                    end
                end
                ST_PAUSE: begin
                    if (temp_ok_i) nxt_d.state = ST_CHARGING;
                end
                default: nxt_d.state = cur_q.state;
            endcase
        end
        nxt_d.loop = (nxt_d.state == ST_CHARGING) ? loop_pick : LP_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= ST_IDLE;
            cur_q.loop  <= LP_NONE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state_o = cur_q.state;
    assign loop_o  = cur_q.loop;

    AST_SHORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        bat_short_i |=> (state_o == 8'h80)); // R2
    AST_MISSING_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        !bat_short_i && !bat_present_i |=> (state_o == 8'h40)); // R2
    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_o) == 1); // R11
    AST_LOOP_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(loop_o)); // R10
    AST_LOOP_ONLY_CHG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 8'h02) |-> (loop_o == 4'h0)); // R10
    AST_PAUSE_HOLDS_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_PAUSE) |=> $stable(tot_cnt)); // R5
    AST_PAUSE_HOLDS_CV: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_PAUSE) |=> $stable(cv_cnt)); // R6
    AST_TERM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_CV_TMO) && chg_en_i && bat_present_i && !bat_short_i
        |=> (cur_q.state == ST_CV_TMO)); // R9

endmodule

// File: tb/test_li_charge_seq.sv
`timescale 1ns/1ps
module test_li_charge_seq;

    localparam logic [7:0] S_IDLE = 8'h01, S_CHG = 8'h02, S_PAUSE = 8'h04, S_CVT = 8'h08;
    localparam logic [7:0] S_CX = 8'h10, S_TF = 8'h20, S_NB = 8'h40, S_SH = 8'h80;
    localparam logic [3:0] L_NONE = 4'h0, L_CV = 4'h1, L_CC = 4'h2, L_IIN = 4'h4, L_UV = 4'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, en = 1'b0, present = 1'b1, shorted = 1'b0, temp = 1'b1;
    logic        uv = 1'b0, iin = 1'b0;
    logic [15:0] ibat = 16'd500, vbat = 16'd100, vtgt = 16'd200, cx = 16'd50;
    logic [15:0] max_cv = 16'd100, max_tot = 16'd3;
    logic [7:0]  state;
    logic [3:0]  loop;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_st_q[$];
    logic [3:0] exp_lp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    li_charge_seq i_li_charge_seq (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .chg_en_i(en),
        .bat_present_i(present), .bat_short_i(shorted), .temp_ok_i(temp),
        .uv_lim_i(uv), .iin_lim_i(iin), .ibat_i(ibat), .vbat_i(vbat),
        .vtarget_i(vtgt), .cx_thresh_i(cx), .max_cv_time_i(max_cv),
        .max_total_time_i(max_tot), .state_o(state), .loop_o(loop)
    );

    // Monitor: pops one expected item per negedge and compares.
    always @(negedge clk) begin
        if (exp_st_q.size() > 0) begin
            logic [7:0] es;
            logic [3:0] el;
            string      t;
            es = exp_st_q.pop_front();
            el = exp_lp_q.pop_front();
            t  = tag_q.pop_front();
            checks++;
            if (state !== es || loop !== el) begin
                errors++;
                $display("FAIL %s: state=%h loop=%h expected state=%h loop=%h", t, state, loop, es, el);
            end
        end
    end

    // Driver: one clock step with the current inputs, then queue what must appear.
    task automatic step(input string t, input logic [7:0] es, input logic [3:0] el);
        @(posedge clk);
        exp_st_q.push_back(es);
        exp_lp_q.push_back(el);
        tag_q.push_back(t);
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (state !== S_IDLE || loop !== L_NONE) begin
            errors++;
            $display("FAIL R1 reset: state=%h loop=%h expected state=%h loop=%h", state, loop, S_IDLE, L_NONE);
        end
        rst_n = 1'b1;
        step("R1 idle after reset", S_IDLE, L_NONE);
        tick = 1'b1;
        step("R1 tick in idle", S_IDLE, L_NONE);
        tick = 1'b0;

        // R3 start and R10 loop priorities
        en = 1'b1;
        step("R3 start", S_CHG, L_CC);
        iin = 1'b1;
        step("R10 input current", S_CHG, L_IIN);
        uv = 1'b1;
        step("R10 undervoltage over current", S_CHG, L_UV);
        uv = 1'b0; iin = 1'b0; vbat = 16'd200;
        step("R10 constant voltage", S_CHG, L_CV);
        vbat = 16'd100;
        step("R10 constant current", S_CHG, L_CC);

        // R5 total timer with pause hold, R4, R8
        tick = 1'b1;
        step("R5 tick 1", S_CHG, L_CC);
        step("R5 tick 2", S_CHG, L_CC);
        tick = 1'b0; temp = 1'b0;
        step("R4 enter pause", S_PAUSE, L_NONE);
        tick = 1'b1;
        for (int i = 0; i < 3; i++) step("R5 pause holds count", S_PAUSE, L_NONE);
        tick = 1'b0; temp = 1'b1;
        step("R4 leave pause", S_CHG, L_CC);
        tick = 1'b1;
        step("R5 tick 3", S_CHG, L_CC);
        step("R5 tick 4", S_CHG, L_CC);
        tick = 1'b0; temp = 1'b0;
        step("R8 pause over time fault", S_PAUSE, L_NONE);
        temp = 1'b1;
        step("R4 resume", S_CHG, L_CC);
        step("R5 total fault", S_TF, L_NONE);
        tick = 1'b1; temp = 1'b0; vbat = 16'd200; ibat = 16'd10;
        step("R9 fault holds a", S_TF, L_NONE);
        step("R9 fault holds b", S_TF, L_NONE);
        tick = 1'b0; temp = 1'b1; vbat = 16'd100; ibat = 16'd500;
        en = 1'b0;
        step("R3 disable to idle", S_IDLE, L_NONE);

        // R5 counter cleared on restart
        en = 1'b1;
        step("R5 restart", S_CHG, L_CC);
        tick = 1'b1;
        for (int i = 0; i < 4; i++) step("R5 count from zero", S_CHG, L_CC);
        tick = 1'b0;
        step("R5 fault after restart", S_TF, L_NONE);
        en = 1'b0;
        step("R3 idle", S_IDLE, L_NONE);

        // R6 constant-voltage timer
        max_tot = 16'd1000; max_cv = 16'd2;
        en = 1'b1;
        step("R6 start", S_CHG, L_CC);
        tick = 1'b1;
        for (int i = 0; i < 3; i++) step("R6 no count in CC", S_CHG, L_CC);
        tick = 1'b0; vbat = 16'd200;
        step("R6 enter CV", S_CHG, L_CV);
        tick = 1'b1;
        for (int i = 0; i < 3; i++) step("R6 CV ticks", S_CHG, L_CV);
        tick = 1'b0;
        step("R6 CV timeout", S_CVT, L_NONE);
        step("R9 timeout holds", S_CVT, L_NONE);
        en = 1'b0;
        step("R3 idle again", S_IDLE, L_NONE);

        // R7 C/x termination
        max_cv = 16'd100; vbat = 16'd100; ibat = 16'd40; en = 1'b1;
        step("R7 start", S_CHG, L_CC);
        step("R7 low current in CC ignored", S_CHG, L_CC);
        vbat = 16'd200;
        step("R7 enter CV", S_CHG, L_CV);
        step("R7 C/x done", S_CX, L_NONE);

        // R2 battery faults
        present = 1'b0;
        step("R2 missing", S_NB, L_NONE);
        shorted = 1'b1;
        step("R2 short over missing", S_SH, L_NONE);
        shorted = 1'b0;
        step("R2 still missing", S_NB, L_NONE);
        present = 1'b1; ibat = 16'd500; vbat = 16'd100;
        step("R2 cleared to idle", S_IDLE, L_NONE);
        step("R3 restart after fault", S_CHG, L_CC);
        temp = 1'b0; shorted = 1'b1;
        step("R2 short over pause", S_SH, L_NONE);
        shorted = 1'b0; temp = 1'b1;
        step("R2 short cleared", S_IDLE, L_NONE);
        step("R11 charging", S_CHG, L_CC);
        en = 1'b0;
        step("R3 final idle", S_IDLE, L_NONE);

        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule